// File: doc/BRIEF.md
# CRC Checker with Control Register

This block checks the integrity of the inbound data stream of a double-transition data-in transfer. Each data word that arrives with a valid strobe is folded into a running 32-bit CRC. When the transfer logic delivers the received CRC word with a check strobe, the block compares that word with the running value. A mismatch sets a sticky error flag. If the checking and interrupt enables are both on, it also sends a one-cycle set pulse toward bit 0 of the first interrupt status register.

An 8-bit control register gives software access to the checker. Through it, software can read and clear the error flag, choose whether the CRC reseeds itself after every check, and drive a data-select output. It also provides three test strobes. These force a reseed, a check or an accumulate in the cycle of the write. The CRC uses the generator 0x04C11DB7, is processed MSB first with no reflection and no final inversion, and starts from an all-ones seed.

Top module: `crc_chk_ctl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), reg_rdata reads 0x00, crc_value reads 0xFFFFFFFF, and crc_err, irq_crc_set and data_sel are 0.
- R2: Each cycle with in_valid high folds in_data into the CRC, MSB first, with generator 0x04C11DB7. The new crc_value is visible in the next cycle. in_data is also kept in an input hold register. With no seed and no accumulate request, crc_value keeps its value.
- R3: A cycle with chk_valid and dt_datain high compares chk_crc with crc_value. On inequality, crc_err is high from the next cycle on. A match leaves it low. chk_valid while dt_datain is low is ignored, and this holds whatever the state of crc_chk_en.
- R4: crc_err is sticky and reads as reg_rdata bit 7. Two things clear it in the following cycle: a register write with bit 7 = 1, or a pulse on stat_rd0 or stat_rd1. A write with bit 7 = 0 leaves it set.
- R5: A mismatch found in the same cycle as a write-1 clear or a status read leaves crc_err set.
- R6: irq_crc_set pulses for one cycle, in the same cycle crc_err becomes set from a mismatch. It pulses only if crc_chk_en and par_irq_en were both high in the cycle of the mismatch.
- R7: Register bit 5 (auto-seed) is read/write. When it is 1, any check made while dt_datain is high reloads crc_value with 0xFFFFFFFF in the next cycle. When it is 0, a check leaves crc_value as it was.
- R8: A pulse on xfer_seed reloads crc_value with 0xFFFFFFFF in the next cycle.
- R9: A write with bit 4 = 1 reloads crc_value with 0xFFFFFFFF in the next cycle, whatever the value of dt_datain. Bit 4 reads back 0.
- R10: A write with bit 3 = 1 compares crc_value with the last chk_crc accepted by a check (0 after reset). A mismatch sets crc_err as in R3. Bit 3 reads back 0.
- R11: A write with bit 2 = 1 folds the input hold register into the CRC, as in R2. Bit 2 reads back 0.
- R12: Register bit 0 is read/write and drives data_sel. Bits 6 and 1 always read 0.
- R13: In one cycle, a reseed request wins over an accumulate. An in_valid word is folded instead of the hold register when the bit-2 strobe arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| in_valid | input | 1 | Data word valid |
| in_data | input | 32 | Inbound data word |
| dt_datain | input | 1 | Transfer is in double-transition data-in |
| chk_valid | input | 1 | Check strobe from the transfer logic |
| chk_crc | input | 32 | Received CRC word for the check |
| xfer_seed | input | 1 | Reseed request from the transfer logic |
| crc_chk_en | input | 1 | CRC checking enable |
| par_irq_en | input | 1 | Parity/CRC interrupt enable |
| stat_rd0 | input | 1 | Read of the first interrupt status register |
| stat_rd1 | input | 1 | Read of the second interrupt status register |
| crc_value | output | 32 | Running CRC value |
| crc_err | output | 1 | Sticky CRC error flag |
| irq_crc_set | output | 1 | Set pulse for interrupt status bit 0 |
| data_sel | output | 1 | Data-select control from register bit 0 |

## Verification
Word runs from a table are mixed with checks that carry the correct CRC or a CRC with bits flipped. This separates a correct fold order and generator from mismatch detection, because one wrong bit in the datapath turns a good check into an error. Directed patterns then put a new error on the same cycle as each kind of clear, so that set priority can be told apart from ordinary clearing. Checks are also made with auto-seed on and off, and with dt_datain low, to separate reseeding from holding and qualified checks from ignored ones. The test strobes are sent alone and together with in_valid or xfer_seed. This shows which source wins and which word gets folded.

// File: rtl/crc_chk_pkg.sv
// Package: shared register bit positions and the test strobe bundle for the
// CRC checker. Assumes an 8-bit control register.
package crc_chk_pkg;
    localparam int CTL_W   = 8;
    localparam int B_ERR   = 7;
    localparam int B_ASEED = 5;
    localparam int B_TSEED = 4;
    localparam int B_TCHK  = 3;
    localparam int B_TADD  = 2;
    localparam int B_DSEL  = 0;

    typedef struct packed {
        logic seed;
        logic chk;
        logic add;
    } tst_cmd_t;
endpackage

// File: rtl/crc_step.sv
// crc_step: combinational fold of one data word into a CRC, MSB first,
// non-reflected. Assumes DATA_W bits are consumed per call, highest first.
module crc_step #(
    parameter int          DATA_W = 32,
    parameter int          CRC_W  = 32,
    parameter logic [31:0] POLY   = 32'h04C11DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    localparam logic [CRC_W-1:0] GEN = POLY[CRC_W-1:0];

    // Shift each data bit through the LFSR in turn.
    always_comb begin
        logic [CRC_W-1:0] r;
        r = crc_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ data[i]) r = {r[CRC_W-2:0], 1'b0} ^ GEN;
            else                      r = {r[CRC_W-2:0], 1'b0};
        end
        crc_out = r;
    end
endmodule

// File: rtl/crc_accum.sv
// crc_accum: running CRC register with seed, accumulate and compare.
// Holds the last input word and the last accepted received CRC. Assumes
// hardware checks count only during double-transition data-in.
module crc_accum
    import crc_chk_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          CRC_W  = 32,
    parameter logic [31:0] POLY   = 32'h04C11DB7,
    parameter logic [31:0] SEED   = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              dt_datain,
    input  logic              chk_valid,
    input  logic [CRC_W-1:0]  chk_crc,
    input  logic              xfer_seed,
    input  logic              auto_seed_en,
    input  tst_cmd_t          tst,
    output logic [CRC_W-1:0]  crc_q,
    output logic              mismatch
);
    localparam logic [CRC_W-1:0] SEED_V = SEED[CRC_W-1:0];

    logic [DATA_W-1:0] in_hold;
    logic [CRC_W-1:0]  rx_hold;
    logic [CRC_W-1:0]  crc_nx;
    logic [DATA_W-1:0] add_word;
    logic hw_chk, chk_any, seed_req, add_req;

    // Qualify checks, pick the reseed and accumulate sources.
    always_comb begin
        hw_chk   = chk_valid & dt_datain;
        chk_any  = hw_chk | tst.chk;
        seed_req = tst.seed | xfer_seed | (auto_seed_en & dt_datain & chk_any);
        add_req  = in_valid | tst.add;
        add_word = in_valid ? in_data : in_hold;
        mismatch = (hw_chk & (crc_q != chk_crc)) | (tst.chk & (crc_q != rx_hold));
    end

    crc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_step (
        .crc_in (crc_q),
        .data   (add_word),
        .crc_out(crc_nx)
    );

    // Running CRC: reseed wins over accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)        crc_q <= SEED_V;
        else if (seed_req) crc_q <= SEED_V;
        else if (add_req)  crc_q <= crc_nx;
    end

    // Hold registers for the last input word and last received CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_hold <= '0;
            rx_hold <= '0;
        end else begin
            if (in_valid) in_hold <= in_data;
            if (hw_chk)   rx_hold <= chk_crc;
        end
    end

    p_xfer_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_seed |=> (crc_q == SEED_V));
    p_test_seed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tst.seed |=> (crc_q == SEED_V));
    p_auto_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_seed_en && dt_datain && chk_valid) |=> (crc_q == SEED_V));
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !tst.add && !tst.seed && !xfer_seed && !(chk_any && auto_seed_en))
        |=> $stable(crc_q));
    p_ignore_chk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !dt_datain && !tst.chk) |-> !mismatch);
endmodule

// File: rtl/crc_ctl_reg.sv
// crc_ctl_reg: 8-bit control/status register. Holds the auto-seed and
// data-select bits, decodes the self-clearing test strobes, and keeps the
// sticky error flag. Assumes a new error wins over any clear in that cycle.
module crc_ctl_reg
    import crc_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             err_set,
    input  logic             chk_en,
    input  logic             irq_en,
    input  logic             stat_rd0,
    input  logic             stat_rd1,
    output logic [CTL_W-1:0] rdata,
    output tst_cmd_t         tst,
    output logic             auto_seed_en,
    output logic             data_sel,
    output logic             crc_err,
    output logic             irq_crc_set
);
    logic err_clr;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[6], wdata[1]};

    // Decode the write-side strobes and the clear sources.
    always_comb begin
        tst.seed = wr & wdata[B_TSEED];
        tst.chk  = wr & wdata[B_TCHK];
        tst.add  = wr & wdata[B_TADD];
        err_clr  = (wr & wdata[B_ERR]) | stat_rd0 | stat_rd1;
    end

    // Read/write control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_seed_en <= 1'b0;
            data_sel     <= 1'b0;
        end else if (wr) begin
            auto_seed_en <= wdata[B_ASEED];
            data_sel     <= wdata[B_DSEL];
        end
    end

    // Sticky error flag and the interrupt set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_err     <= 1'b0;
            irq_crc_set <= 1'b0;
        end else begin
            if (err_set)      crc_err <= 1'b1;
            else if (err_clr) crc_err <= 1'b0;
            irq_crc_set <= err_set & chk_en & irq_en;
        end
    end

    // Read value: strobes and reserved bits read 0.
    always_comb begin
        rdata          = '0;
        rdata[B_ERR]   = crc_err;
        rdata[B_ASEED] = auto_seed_en;
        rdata[B_DSEL]  = data_sel;
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> crc_err);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !err_set) |=> !crc_err);
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !err_clr) |=> crc_err);
    p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crc_set |-> crc_err);
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set && !(chk_en && irq_en)) |=> !irq_crc_set);
endmodule

// File: rtl/crc_chk_ctl.sv
// crc_chk_ctl: top of the CRC checker. Connects the control register to the
// CRC datapath. Assumes one data word per in_valid and a received CRC word
// presented with chk_valid.
module crc_chk_ctl
    import crc_chk_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          CRC_W  = 32,
    parameter logic [31:0] POLY   = 32'h04C11DB7,
    parameter logic [31:0] SEED   = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              dt_datain,
    input  logic              chk_valid,
    input  logic [CRC_W-1:0]  chk_crc,
    input  logic              xfer_seed,
    input  logic              crc_chk_en,
    input  logic              par_irq_en,
    input  logic              stat_rd0,
    input  logic              stat_rd1,
    output logic [CRC_W-1:0]  crc_value,
    output logic              crc_err,
    output logic              irq_crc_set,
    output logic              data_sel
);
    tst_cmd_t tst;
    logic     auto_seed_en;
    logic     mismatch;

    crc_ctl_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .wdata       (reg_wdata),
        .err_set     (mismatch),
        .chk_en      (crc_chk_en),
        .irq_en      (par_irq_en),
        .stat_rd0    (stat_rd0),
        .stat_rd1    (stat_rd1),
        .rdata       (reg_rdata),
        .tst         (tst),
        .auto_seed_en(auto_seed_en),
        .data_sel    (data_sel),
        .crc_err     (crc_err),
        .irq_crc_set (irq_crc_set)
    );

    crc_accum #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .dt_datain   (dt_datain),
        .chk_valid   (chk_valid),
        .chk_crc     (chk_crc),
        .xfer_seed   (xfer_seed),
        .auto_seed_en(auto_seed_en),
        .tst         (tst),
        .crc_q       (crc_value),
        .mismatch    (mismatch)
    );
endmodule

// File: tb/tb_crc_chk_ctl.sv
module tb_crc_chk_ctl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        dt_datain = 1'b0;
    logic        chk_valid = 1'b0;
    logic [31:0] chk_crc = '0;
    logic        xfer_seed = 1'b0;
    logic        crc_chk_en = 1'b0;
    logic        par_irq_en = 1'b0;
    logic        stat_rd0 = 1'b0;
    logic        stat_rd1 = 1'b0;
    logic [31:0] crc_value;
    logic        crc_err, irq_crc_set, data_sel;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_crc = 32'hFFFFFFFF;
    logic [31:0] m_in = '0;
    logic [31:0] m_rx = '0;

    // op 0: fold word; op 1: check with the right CRC; op 2: check with word XORed in
    localparam logic [33:0] VEC [0:9] = '{
        {2'd0, 32'h12345678}, {2'd0, 32'hDEADBEEF}, {2'd1, 32'h0},
        {2'd0, 32'h00000000}, {2'd2, 32'h00000001}, {2'd0, 32'hFFFFFFFF},
        {2'd0, 32'h80000000}, {2'd1, 32'h0}, {2'd0, 32'hA5A5A5A5},
        {2'd2, 32'h40000000}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_chk_ctl dut (.*);

    function automatic logic [31:0] bcrc(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 31; i >= 0; i--)
            r = (r[31] ^ d[i]) ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic acc(input logic [31:0] w);
        in_valid = 1'b1; in_data = w;
        tick;
        in_valid = 1'b0;
        m_crc = bcrc(m_crc, w); m_in = w;
    endtask

    task automatic hwchk(input logic [31:0] c);
        chk_valid = 1'b1; chk_crc = c;
        tick;
        chk_valid = 1'b0;
        if (dt_datain) m_rx = c;
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        tick;
        reg_wr = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) tick;
        check("R1 rdata", {24'h0, reg_rdata}, 32'h0);
        check("R1 crc", crc_value, 32'hFFFFFFFF);
        check("R1 err/irq/dsel", {29'h0, crc_err, irq_crc_set, data_sel}, 32'h0);
        rst_n = 1'b1;
        dt_datain = 1'b1; crc_chk_en = 1'b1; par_irq_en = 1'b1;
        tick;

        // table walk: fold, good checks, bad checks
        for (int i = 0; i < 10; i++) begin
            case (VEC[i][33:32])
                2'd0: begin
                    acc(VEC[i][31:0]);
                    check("R2 fold", crc_value, m_crc);
                end
                2'd1: begin
                    hwchk(m_crc);
                    check("R3 good check", {31'h0, crc_err}, 32'h0);
                    check("R7 no reseed", crc_value, m_crc);
                end
                default: begin
                    hwchk(m_crc ^ VEC[i][31:0]);
                    check("R3 bad check", {31'h0, crc_err}, 32'h1);
                    check("R6 irq pulse", {31'h0, irq_crc_set}, 32'h1);
                    wr(8'h80);
                    check("R4 w1c", {31'h0, crc_err}, 32'h0);
                    check("R6 irq one cycle", {31'h0, irq_crc_set}, 32'h0);
                end
            endcase
        end

        // sticky, write-0 and status-read clears
        hwchk(~m_crc);
        repeat (3) tick;
        check("R4 sticky", {31'h0, crc_err}, 32'h1);
        wr(8'h00);
        check("R4 write 0 keeps", {31'h0, crc_err}, 32'h1);
        stat_rd1 = 1'b1; tick; stat_rd1 = 1'b0;
        check("R4 stat_rd1 clear", {31'h0, crc_err}, 32'h0);
        hwchk(~m_crc);
        stat_rd0 = 1'b1; tick; stat_rd0 = 1'b0;
        check("R4 stat_rd0 clear", {31'h0, crc_err}, 32'h0);

        // set wins over both clears
        chk_valid = 1'b1; chk_crc = ~m_crc; reg_wr = 1'b1; reg_wdata = 8'h80;
        tick;
        chk_valid = 1'b0; reg_wr = 1'b0; m_rx = chk_crc;
        check("R5 set over w1c", {31'h0, crc_err}, 32'h1);
        chk_valid = 1'b1; stat_rd0 = 1'b1;
        tick;
        chk_valid = 1'b0; stat_rd0 = 1'b0;
        check("R5 set over status read", {31'h0, crc_err}, 32'h1);
        wr(8'h80);

        // interrupt gating
        crc_chk_en = 1'b0;
        hwchk(~m_crc);
        check("R3 flag without enable", {31'h0, crc_err}, 32'h1);
        check("R6 no irq chk_en=0", {31'h0, irq_crc_set}, 32'h0);
        wr(8'h80);
        crc_chk_en = 1'b1; par_irq_en = 1'b0;
        hwchk(~m_crc);
        check("R6 no irq irq_en=0", {31'h0, irq_crc_set}, 32'h0);
        wr(8'h80);
        par_irq_en = 1'b1;

        // check ignored outside data-in
        dt_datain = 1'b0;
        hwchk(~m_crc);
        check("R3 ignored err", {31'h0, crc_err}, 32'h0);
        check("R3 ignored crc", crc_value, m_crc);
        dt_datain = 1'b1;

        // auto-seed on
        wr(8'h20);
        check("R7 readback", {24'h0, reg_rdata}, 32'h20);
        acc(32'h0BADF00D);
        hwchk(m_crc);
        m_crc = 32'hFFFFFFFF;
        check("R7 auto reseed", crc_value, 32'hFFFFFFFF);
        check("R7 match no err", {31'h0, crc_err}, 32'h0);
        wr(8'h00);

        // transfer reseed
        acc(32'h13579BDF);
        xfer_seed = 1'b1; tick; xfer_seed = 1'b0;
        m_crc = 32'hFFFFFFFF;
        check("R8 xfer reseed", crc_value, 32'hFFFFFFFF);

        // test reseed, outside data-in
        acc(32'h2468ACE0);
        dt_datain = 1'b0;
        wr(8'h30);
        m_crc = 32'hFFFFFFFF;
        check("R9 test reseed", crc_value, 32'hFFFFFFFF);
        check("R9 reads 0", {24'h0, reg_rdata}, 32'h20);
        wr(8'h00);

        // test check
        dt_datain = 1'b1;
        acc(32'h55AA55AA);
        hwchk(m_crc);
        dt_datain = 1'b0;
        wr(8'h08);
        check("R10 test check match", {31'h0, crc_err}, 32'h0);
        check("R10 reads 0", {24'h0, reg_rdata}, 32'h0);
        acc(32'h00000007);
        wr(8'h08);
        check("R10 test check mismatch", {31'h0, crc_err}, 32'h1);
        stat_rd0 = 1'b1; tick; stat_rd0 = 1'b0;

        // test accumulate from the hold register
        wr(8'h04);
        m_crc = bcrc(m_crc, m_in);
        check("R11 test accumulate", crc_value, m_crc);

        // priorities
        in_valid = 1'b1; in_data = 32'hCAFEBABE; reg_wr = 1'b1; reg_wdata = 8'h04;
        tick;
        in_valid = 1'b0; reg_wr = 1'b0;
        m_crc = bcrc(m_crc, 32'hCAFEBABE); m_in = 32'hCAFEBABE;
        check("R13 in_valid over hold", crc_value, m_crc);
        in_valid = 1'b1; in_data = 32'h11111111; xfer_seed = 1'b1;
        tick;
        in_valid = 1'b0; xfer_seed = 1'b0;
        m_crc = 32'hFFFFFFFF; m_in = 32'h11111111;
        check("R13 seed over fold", crc_value, 32'hFFFFFFFF);

        // layout: reserved bits and data select
        wr(8'h63);
        check("R12 readback", {24'h0, reg_rdata}, 32'h21);
        check("R12 data_sel", {31'h0, data_sel}, 32'h1);
        wr(8'h02);
        check("R12 reserved bit 1", {24'h0, reg_rdata}, 32'h0);

        // reset again
        acc(32'h01020304);
        rst_n = 1'b0; tick; rst_n = 1'b1;
        check("R1 re-reset crc", crc_value, 32'hFFFFFFFF);

        finish_run();
    end
endmodule